// File: doc/BRIEF.md
# Measurement Snapshot Latch Controller

This block freezes a coherent copy of two 16-bit measurement values so that a slow host, which reads one byte at a time, never sees a word made of halves from different samples. One value is an auxiliary reading. The other is a per-channel DC value picked from eight stereo filter outputs, either low-pass or high-pass filtered.

The host controls the block through one 8-bit control register behind a simple register write/read port. Setting the trigger bit from 0 to 1 starts a fixed four-step capture: detect the edge, drop both ready flags, copy the values, then raise the flags again. The host polls the flags and then fetches the frozen words as high and low bytes. A bypass bit lets DC reads return the live selected value with no capture step.

Top module: `meas_snapshot_latch`

## Requirements
- R1: The control register at address 0 reads as {bypass[7], aux ready[6], dc ready[5], trigger[4], data type[3], channel[2:0]}. Every bit is 0 after reset, and host writes to bits 7, 4, 3 and 2:0 read back unchanged.
- R2: A capture starts only when the trigger bit goes from 0 to 1. Writing the trigger as 1 again while it is already 1 starts no new capture, so the held values do not change.
- R3: After the clock edge that writes the trigger from 0 to 1, the aux ready flag reads 0 from the second clock edge on. It reads 1 again from the fourth edge on, when the new auxiliary value is held.
- R4: The DC ready flag follows the same timing as the aux ready flag and always reads the same value.
- R5: Data type 0 captures the low-pass value and data type 1 captures the high-pass value of the chosen channel.
- R6: The channel field selects the source: 0 CH1_L, 1 CH1_R, 2 CH2_L, 3 CH2_R, 4 CH3_L, 5 CH3_R, 6 CH4_L, 7 CH4_R. Channel n is bits [16n+15:16n] of the filter input buses.
- R7: With bypass = 1, reads of addresses 3 and 4 return the high and low byte of the live value chosen by the current channel and data type fields. With bypass = 0 they return the held DC value.
- R8: Host writes to bits 6 and 5 of the control register have no effect on the ready flags.
- R9: A change of channel or data type, and a new 0-to-1 trigger edge, both have no effect while a capture is running. The capture uses the selection present at its own trigger edge.
- R10: Reads of address 1 and 2 return the held auxiliary value (high byte, low byte), and reads of 3 and 4 return the held DC value. The held values change only at the copy step of a capture. Reads of addresses 5 to 7 return 0, and writes to any address other than 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address (combinational read) |
| rd_data | output | 8 | Read data |
| aux_live | input | 16 | Live auxiliary measurement |
| lpf_live | input | 128 | Live low-pass values, 16 bits per channel |
| hpf_live | input | 128 | Live high-pass values, 16 bits per channel |

## Verification
The bench goes after the trigger held at 1. A design that detects levels instead of edges would recapture and let the held bytes drift with the changing inputs. It rewrites the channel and data type, and fires new trigger edges, during a running capture. A design that samples the selection late, or restarts, would latch the wrong channel or stretch the ready-low window. It writes ones into the flag bits, which a naive register would store. It also toggles bypass against constantly changing live inputs, which shows a DC read path that mixes up live and held data.

// File: rtl/meas_snapshot_latch.sv
module meas_snapshot_latch #(
  parameter int DW  = 16,
  parameter int NCH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [2:0]         rd_addr,
  output logic [7:0]         rd_data,
  input  logic [DW-1:0]      aux_live,
  input  logic [NCH*DW-1:0]  lpf_live,
  input  logic [NCH*DW-1:0]  hpf_live
);
  localparam int CW = $clog2(NCH);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_CLR = 2'd1, ST_COPY = 2'd2, ST_SET = 2'd3;

  logic          byp_q, trig_q, trig_d, dt_q, sel_dt, rdy;
  logic [CW-1:0] ch_q, sel_ch;
  logic [1:0]    state;
  logic [DW-1:0] aux_hold, dc_hold;

  wire ctrl_wr = wr_en && (wr_addr == 3'd0);
  wire edge_go = trig_q && !trig_d && (state == ST_IDLE);

  wire [DW-1:0] cap_src  = sel_dt ? hpf_live[sel_ch*DW +: DW] : lpf_live[sel_ch*DW +: DW];
  wire [DW-1:0] live_src = dt_q   ? hpf_live[ch_q*DW +: DW]   : lpf_live[ch_q*DW +: DW];
  wire [DW-1:0] dc_rd    = byp_q ? live_src : dc_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0; trig_q <= 1'b0; dt_q <= 1'b0; ch_q <= '0;
      trig_d <= 1'b0;
    end else begin
      trig_d <= trig_q;
      if (ctrl_wr) begin
        byp_q  <= wr_data[7];
        trig_q <= wr_data[4];
        dt_q   <= wr_data[3];
        ch_q   <= wr_data[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; rdy <= 1'b0; sel_ch <= '0; sel_dt <= 1'b0;
      aux_hold <= '0; dc_hold <= '0;
    end else begin
      case (state)
        ST_IDLE: if (edge_go) begin
          sel_ch <= ch_q;
          sel_dt <= dt_q;
          state  <= ST_CLR;
        end
        ST_CLR: begin
          rdy   <= 1'b0;
          state <= ST_COPY;
        end
        ST_COPY: begin
          aux_hold <= aux_live;
          dc_hold  <= cap_src;
          state    <= ST_SET;
        end
        default: begin
          rdy   <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {byp_q, rdy, rdy, trig_q, dt_q, ch_q};
      3'd1:    rd_data = aux_hold[DW-1 -: 8];
      3'd2:    rd_data = aux_hold[7:0];
      3'd3:    rd_data = dc_rd[DW-1 -: 8];
      3'd4:    rd_data = dc_rd[7:0];
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module meas_snapshot_latch_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic [1:0]    state,
  input logic          rdy,
  input logic          trig_q,
  input logic          trig_d,
  input logic [DW-1:0] aux_hold,
  input logic [DW-1:0] dc_hold
);
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && trig_q && trig_d) |=> (state == 2'd0)); // R2
  AST_RDY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> ($past(state) == 2'd1)); // R3
  AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ($past(state) == 2'd3)); // R4
  AST_FLAG_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && wr_data[6:5] != 2'b00 && state == 2'd0) |=> $stable(rdy)); // R8
  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd2) |=> $stable(aux_hold)); // R10
  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd2) |=> $stable(dc_hold)); // R10
endmodule

bind meas_snapshot_latch meas_snapshot_latch_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .state(state), .rdy(rdy), .trig_q(trig_q), .trig_d(trig_d),
  .aux_hold(aux_hold), .dc_hold(dc_hold)
);

// File: tb/tb_meas_snapshot_latch.sv
module tb_meas_snapshot_latch;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0, rd_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [7:0]   rd_data;
  logic [15:0]  aux_live = '0;
  logic [127:0] lpf_live = '0, hpf_live = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  meas_snapshot_latch dut (.*);

  always #5 clk = ~clk;

  // behavioural reference state
  bit m_byp, m_trig, m_dt, m_rdy, m_prev, m_sdt;
  int m_ch, m_sch, m_phase;
  logic [15:0] m_aux, m_dc;

  function automatic logic [15:0] pick(int c, bit d);
    return d ? hpf_live[c*16 +: 16] : lpf_live[c*16 +: 16];
  endfunction

  function automatic logic [7:0] expect_rd(int a);
    logic [15:0] v;
    v = m_byp ? pick(m_ch, m_dt) : m_dc;
    case (a)
      0: return {m_byp, m_rdy, m_rdy, m_trig, m_dt, 3'(m_ch)};
      1: return m_aux[15:8];
      2: return m_aux[7:0];
      3: return v[15:8];
      4: return v[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_byp = 0; m_trig = 0; m_dt = 0; m_rdy = 0; m_prev = 0; m_sdt = 0;
    m_ch = 0; m_sch = 0; m_phase = 0; m_aux = '0; m_dc = '0;
  endtask

  task automatic model_clock();
    bit old_trig;
    old_trig = m_trig;
    case (m_phase)
      0: if (m_trig && !m_prev) begin m_sch = m_ch; m_sdt = m_dt; m_phase = 1; end
      1: begin m_rdy = 0; m_phase = 2; end
      2: begin m_aux = aux_live; m_dc = pick(m_sch, m_sdt); m_phase = 3; end
      default: begin m_rdy = 1; m_phase = 0; end
    endcase
    m_prev = old_trig;
    if (wr_en && wr_addr == 3'd0) begin
      m_byp = wr_data[7]; m_trig = wr_data[4]; m_dt = wr_data[3]; m_ch = int'(wr_data[2:0]);
    end
  endtask

  task automatic check(string tag, int a);
    logic [7:0] e;
    e = expect_rd(a);
    checks++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s addr %0d: actual %02h expected %02h", tag, a, rd_data, e);
    end
  endtask

  task automatic step(bit we, int wa, int wd, int ra, string tag);
    @(negedge clk);
    wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd); rd_addr = 3'(ra);
    aux_live = 16'($urandom);
    lpf_live = {$urandom, $urandom, $urandom, $urandom};
    hpf_live = {$urandom, $urandom, $urandom, $urandom};
    @(posedge clk);
    model_clock();
    #1;
    check(tag, ra);
  endtask

  task automatic idle_reads(int n, int ra, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, ra, tag);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 8; a++) step(0, 0, 0, a, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1; check("R1 R10 reset", a); @(negedge clk);
    end

    // R8 flag bits written by host
    step(1, 0, 8'h60, 0, "R8");
    idle_reads(3, 0, "R8");
    // R1 readback of writable fields
    step(1, 0, 8'h8F, 0, "R1");
    step(1, 0, 8'h00, 0, "R1");
    // R3 R4 flag timing of a capture
    step(1, 0, 8'h10, 0, "R3 R4");
    idle_reads(6, 0, "R3 R4");
    sweep("R5 R6 R10");
    // R2 trigger held at 1
    step(1, 0, 8'h10, 1, "R2");
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 0, 8'h10, 1 + i % 4, "R2 R10");
    // R10 writes to non-control addresses
    step(1, 3, 8'hFF, 3, "R10");
    step(1, 1, 8'hFF, 1, "R10");
    // R5 R6 high-pass on channel 5
    step(1, 0, 8'h00, 0, "R5");
    step(1, 0, 8'h1D, 0, "R5 R6");
    idle_reads(5, 0, "R5 R6");
    sweep("R5 R6");
    // R9 selection change and re-trigger during capture
    step(1, 0, 8'h00, 0, "R9");
    step(1, 0, 8'h12, 0, "R9");
    step(1, 0, 8'h1F, 0, "R9");
    step(1, 0, 8'h07, 0, "R9");
    step(1, 0, 8'h17, 0, "R9");
    idle_reads(4, 0, "R9");
    sweep("R9");
    // R7 bypass against live inputs
    step(1, 0, 8'h8B, 3, "R7");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 3 + i % 2, "R7");
    step(1, 0, 8'h84, 4, "R7");
    idle_reads(4, 3, "R7");
    step(1, 0, 8'h04, 3, "R7");
    idle_reads(2, 4, "R7");
    // R5 R6 every channel and data type
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 2; d++) begin
        step(1, 0, 8'h00, 0, "R6");
        step(1, 0, 8'h10 | (d << 3) | c, 0, "R5 R6");
        idle_reads(4, 0, "R3 R4");
        step(0, 0, 0, 3, "R5 R6");
        step(0, 0, 0, 4, "R5 R6");
      end
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 3) step(1, 0, int'($urandom % 256), int'($urandom % 8), "R1 R2 R9 R10");
      else if (r == 3) step(1, int'($urandom % 8), int'($urandom % 256), int'($urandom % 8), "R2 R10");
      else step(0, 0, 0, int'($urandom % 8), "R3 R7 R10");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule